// File: doc/BRIEF.md
# Memory-Card Host Event Router

This block collects the event flags of a memory-card host controller into a sticky pending register. It filters them through a 13-bit software mask and drives one CPU interrupt line and two DMA request lines, one for receive and one for transmit. Controller logic raises individual sources with one-cycle set strobes. Specific accesses lower them: a clock start command, a read of the receive data port, or a write to the transmit data port.

When DMA mode is on, the receive-FIFO and transmit-FIFO service requests are taken out of the interrupt. They drive the dedicated DMA request lines instead, so a DMA engine can move data without waking the CPU. When DMA mode is off, both DMA lines stay low and those two requests reach the interrupt through the mask like any other source.

Each output is a register. Every output reflects the pending, mask and DMA-mode state captured at the same clock edge.

Top module: `mmc_irq_router`

## Requirements
- R1: A synchronous reset clears the pending register, the mask register, the interrupt line and both DMA lines.
- R2: A set strobe on source i makes pending bit i read 1 after the next clock edge. The bit then stays set until one of the clearing accesses listed in R7 or R8 removes it. Only bits 4, 5 and 6 have a clearing access.
- R3: A mask write stores only bits 12..0 of the 32-bit write data. Bits 31..13 are ignored.
- R4: The interrupt line is 1 exactly when some pending bit is 1 and its effective mask bit is 0. It changes at the same edge that captures the change in pending, mask or DMA mode.
- R5: With DMA mode on, the effective mask also covers bit 5 (receive request) and bit 6 (transmit request), so those two bits never raise the interrupt.
- R6: With DMA mode on, the receive DMA line equals pending bit 5 and the transmit DMA line equals pending bit 6. With DMA mode off, both DMA lines are 0.
- R7: A clock-start command clears pending bit 4 (clock off), and a clock-stop command sets it. When both commands arrive in the same cycle, the bit ends up set.
- R8: A read of the receive data port clears pending bit 5, and a write to the transmit data port clears pending bit 6. Neither access changes any other bit.
- R9: When a set strobe and a clearing access hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 13 | One-cycle set strobes, one per source (bit 0 data done through bit 12 SDIO acknowledge) |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 32 | Mask write data; only bits 12..0 are kept |
| dma_mode | input | 1 | DMA mode enable level from the command control register |
| clk_start_cmd | input | 1 | Clock-start command strobe |
| clk_stop_cmd | input | 1 | Clock-stop command strobe |
| rx_port_rd | input | 1 | Receive data port read strobe |
| tx_port_wr | input | 1 | Transmit data port write strobe |
| pend_o | output | 13 | Pending register |
| mask_o | output | 13 | Mask register |
| irq_o | output | 1 | CPU interrupt request |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |

## Verification
Two cases are hard to reach from the ports. One is a collision, where a set strobe and a clearing access land on the same bit in one cycle. The other is a DMA-mode change while the FIFO requests are pending. Every source except bits 4 to 6 is sticky, so the stimulus resets the block again before each DMA scenario. It then drives the colliding strobes in the same cycle and toggles DMA mode with bits 5 and 6 held pending. This shows the requests moving between the interrupt and the DMA lines without any change to the pending state.

// File: rtl/mmc_irq_pkg.sv
package mmc_irq_pkg;
  localparam int NSRC      = 13;
  localparam int BUS_W     = 32;
  // bit positions that carry individual behaviour
  localparam int IDX_CLKOFF = 4;
  localparam int IDX_RXREQ  = 5;
  localparam int IDX_TXREQ  = 6;

  typedef struct packed {
    logic irq;
    logic rx_dreq;
    logic tx_dreq;
  } route_t;
endpackage

// File: rtl/mmc_irq_pending.sv
module mmc_irq_pending #(
  parameter int NSRC = mmc_irq_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] pend_nx,
  output logic [NSRC-1:0] pend_q
);
  // set has priority over clear in every bit
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb pend_nx[i] = set_vec[i] | (pend_q[i] & ~clr_vec[i]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_nx[i];
    end
  end
endmodule

// File: rtl/mmc_irq_mask.sv
module mmc_irq_mask #(
  parameter int NSRC  = mmc_irq_pkg::NSRC,
  parameter int BUS_W = mmc_irq_pkg::BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output logic [NSRC-1:0]  mask_nx,
  output logic [NSRC-1:0]  mask_q
);
  always_comb mask_nx = we ? wdata[NSRC-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nx;
  end
endmodule

// File: rtl/mmc_irq_combine.sv
module mmc_irq_combine
  import mmc_irq_pkg::*;
#(
  parameter int NSRC = mmc_irq_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_nx,
  input  logic [NSRC-1:0] mask_nx,
  input  logic            dma_mode,
  output route_t          route_q
);
  logic [NSRC-1:0] eff_mask;
  route_t          route_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_eff
    if (i == IDX_RXREQ || i == IDX_TXREQ) begin : g_fifo
      always_comb eff_mask[i] = mask_nx[i] | dma_mode;
    end else begin : g_plain
      always_comb eff_mask[i] = mask_nx[i];
    end
  end

  always_comb begin
    route_d.irq     = |(pend_nx & ~eff_mask);
    route_d.rx_dreq = dma_mode & pend_nx[IDX_RXREQ];
    route_d.tx_dreq = dma_mode & pend_nx[IDX_TXREQ];
  end

  always_ff @(posedge clk) begin
    if (rst) route_q <= '0;
    else     route_q <= route_d;
  end
endmodule

// File: rtl/mmc_irq_router.sv
module mmc_irq_router
  import mmc_irq_pkg::*;
#(
  parameter int NSRC  = mmc_irq_pkg::NSRC,
  parameter int BUS_W = mmc_irq_pkg::BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_set,
  input  logic             mask_we,
  input  logic [BUS_W-1:0] mask_wdata,
  input  logic             dma_mode,
  input  logic             clk_start_cmd,
  input  logic             clk_stop_cmd,
  input  logic             rx_port_rd,
  input  logic             tx_port_wr,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  mask_o,
  output logic             irq_o,
  output logic             rx_dreq_o,
  output logic             tx_dreq_o
);
  logic [NSRC-1:0] set_all, clr_all, pend_nx, mask_nx;
  route_t          route_q;

  always_comb begin
    set_all = src_set;
    set_all[IDX_CLKOFF] = src_set[IDX_CLKOFF] | clk_stop_cmd;
    clr_all = '0;
    clr_all[IDX_CLKOFF] = clk_start_cmd;
    clr_all[IDX_RXREQ]  = rx_port_rd;
    clr_all[IDX_TXREQ]  = tx_port_wr;
  end

  mmc_irq_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .set_vec(set_all), .clr_vec(clr_all),
    .pend_nx(pend_nx), .pend_q(pend_o)
  );

  mmc_irq_mask #(.NSRC(NSRC), .BUS_W(BUS_W)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we), .wdata(mask_wdata),
    .mask_nx(mask_nx), .mask_q(mask_o)
  );

  mmc_irq_combine #(.NSRC(NSRC)) u_comb (
    .clk(clk), .rst(rst), .pend_nx(pend_nx), .mask_nx(mask_nx),
    .dma_mode(dma_mode), .route_q(route_q)
  );

  assign irq_o     = route_q.irq;
  assign rx_dreq_o = route_q.rx_dreq;
  assign tx_dreq_o = route_q.tx_dreq;
endmodule

// File: rtl/mmc_irq_router_chk.sv
module mmc_irq_router_chk
  import mmc_irq_pkg::*;
#(
  parameter int NSRC  = mmc_irq_pkg::NSRC,
  parameter int BUS_W = mmc_irq_pkg::BUS_W
) (
  input logic             clk,
  input logic             rst,
  input logic [NSRC-1:0]  src_set,
  input logic             mask_we,
  input logic [BUS_W-1:0] mask_wdata,
  input logic             dma_mode,
  input logic             clk_stop_cmd,
  input logic             rx_port_rd,
  input logic             tx_port_wr,
  input logic [NSRC-1:0]  pend_o,
  input logic [NSRC-1:0]  mask_o,
  input logic             irq_o,
  input logic             rx_dreq_o,
  input logic             tx_dreq_o
);
  logic [NSRC-1:0] fifo_bits;
  always_comb begin
    fifo_bits = '0;
    fifo_bits[IDX_RXREQ] = 1'b1;
    fifo_bits[IDX_TXREQ] = 1'b1;
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pend_o == '0 && mask_o == '0 && !irq_o && !rx_dreq_o && !tx_dreq_o));

  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (|src_set) |=> ((pend_o & $past(src_set)) == $past(src_set)));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_o == $past(mask_wdata[NSRC-1:0])));

  p_irq_match_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |(pend_o & ~(mask_o | ($past(dma_mode) ? fifo_bits : '0)))));

  p_dma_off_r6: assert property (@(posedge clk) disable iff (rst)
    !dma_mode |=> (!rx_dreq_o && !tx_dreq_o));

  p_clkoff_set_r7: assert property (@(posedge clk) disable iff (rst)
    clk_stop_cmd |=> pend_o[IDX_CLKOFF]);

  p_rx_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_port_rd && !src_set[IDX_RXREQ]) |=> !pend_o[IDX_RXREQ]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_port_wr && src_set[IDX_TXREQ]) |=> pend_o[IDX_TXREQ]);
endmodule

bind mmc_irq_router mmc_irq_router_chk #(.NSRC(NSRC), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .src_set(src_set), .mask_we(mask_we),
  .mask_wdata(mask_wdata), .dma_mode(dma_mode), .clk_stop_cmd(clk_stop_cmd),
  .rx_port_rd(rx_port_rd), .tx_port_wr(tx_port_wr), .pend_o(pend_o),
  .mask_o(mask_o), .irq_o(irq_o), .rx_dreq_o(rx_dreq_o), .tx_dreq_o(tx_dreq_o)
);

// File: tb/mmc_irq_router_tb_top.sv
`timescale 1ns/1ps
module mmc_irq_router_tb_top;
  localparam int N = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic [N-1:0]  src_set = '0;
  logic          mask_we = 1'b0;
  logic [31:0]   mask_wdata = '0;
  logic          dma_mode = 1'b0;
  logic          clk_start_cmd = 1'b0, clk_stop_cmd = 1'b0;
  logic          rx_port_rd = 1'b0, tx_port_wr = 1'b0;
  logic [N-1:0]  pend_o, mask_o;
  logic          irq_o, rx_dreq_o, tx_dreq_o;

  mmc_irq_router dut_i (
    .clk(clk), .rst(rst), .src_set(src_set), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .dma_mode(dma_mode), .clk_start_cmd(clk_start_cmd),
    .clk_stop_cmd(clk_stop_cmd), .rx_port_rd(rx_port_rd), .tx_port_wr(tx_port_wr),
    .pend_o(pend_o), .mask_o(mask_o), .irq_o(irq_o),
    .rx_dreq_o(rx_dreq_o), .tx_dreq_o(tx_dreq_o)
  );

  typedef struct {
    logic [N-1:0] pend;
    logic [N-1:0] mask;
    logic         irq, rx, tx;
    string        tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  logic [N-1:0] m_pend = '0, m_mask = '0;

  // monitor: compare one expected item shortly after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (pend_o !== e.pend || mask_o !== e.mask || irq_o !== e.irq ||
          rx_dreq_o !== e.rx || tx_dreq_o !== e.tx) begin
        errors++;
        $display("FAIL %s: got pend=%h mask=%h irq=%b rx=%b tx=%b exp pend=%h mask=%h irq=%b rx=%b tx=%b",
                 e.tag, pend_o, mask_o, irq_o, rx_dreq_o, tx_dreq_o,
                 e.pend, e.mask, e.irq, e.rx, e.tx);
      end
    end
  end

  // driver: applies one cycle of stimulus and predicts the result
  task automatic step(input logic r, input logic [N-1:0] s, input logic mwe,
                      input logic [31:0] md, input logic dm, input logic st,
                      input logic sp, input logic rr, input logic tw, input string tag);
    exp_t e;
    logic [N-1:0] setv, clrv, effm;
    @(negedge clk);
    rst = r; src_set = s; mask_we = mwe; mask_wdata = md; dma_mode = dm;
    clk_start_cmd = st; clk_stop_cmd = sp; rx_port_rd = rr; tx_port_wr = tw;
    if (r) begin
      m_pend = '0; m_mask = '0;
      e.irq = 0; e.rx = 0; e.tx = 0;
    end else begin
      setv = s; setv[4] = setv[4] | sp;
      clrv = '0; clrv[4] = st; clrv[5] = rr; clrv[6] = tw;
      m_pend = setv | (m_pend & ~clrv);
      if (mwe) m_mask = md[N-1:0];
      effm = m_mask; effm[5] = effm[5] | dm; effm[6] = effm[6] | dm;
      e.irq = |(m_pend & ~effm);
      e.rx = dm & m_pend[5];
      e.tx = dm & m_pend[6];
    end
    e.pend = m_pend; e.mask = m_mask; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic dm, input string tag);
    step(0, '0, 0, '0, dm, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset(input string tag);
    step(1, '0, 0, '0, 0, 0, 0, 0, 0, tag);
    step(1, '0, 0, '0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    do_reset("R1 reset state");
    idle(0, "R1 after reset");
    step(0, 13'h0001, 0, '0, 0, 0, 0, 0, 0, "R2 R4 set data done");
    idle(0, "R2 sticky");
    step(0, '0, 1, 32'hFFFF_E001, 0, 0, 0, 0, 0, "R3 mask upper bits dropped");
    step(0, 13'h0200, 0, '0, 0, 0, 0, 0, 0, "R4 response error unmasked");
    step(0, '0, 1, 32'h0000_1FFF, 0, 0, 0, 0, 0, "R4 all masked");
    // DMA routing
    do_reset("R1 reset before DMA");
    step(0, 13'h0060, 0, '0, 1, 0, 0, 0, 0, "R5 R6 fifo requests to DMA");
    idle(0, "R6 DMA off drops lines");
    idle(1, "R5 DMA on again");
    step(0, '0, 0, '0, 1, 0, 0, 1, 0, "R8 rx read clears bit5");
    step(0, 13'h0040, 0, '0, 1, 0, 0, 0, 1, "R9 tx set beats tx write");
    step(0, '0, 0, '0, 1, 0, 0, 0, 1, "R8 tx write clears bit6");
    step(0, '0, 1, 32'h0000_0040, 0, 0, 0, 0, 0, "R4 mask write only");
    step(0, '0, 0, '0, 0, 0, 1, 0, 0, "R7 stop sets clock off");
    step(0, '0, 0, '0, 0, 1, 0, 0, 0, "R7 start clears clock off");
    step(0, '0, 0, '0, 0, 1, 1, 0, 0, "R7 start and stop together");
    step(0, '0, 0, '0, 0, 1, 0, 0, 0, "R7 start clears again");
    step(0, 13'h0020, 0, '0, 0, 0, 0, 1, 0, "R9 rx set beats rx read");
    step(0, '0, 0, '0, 0, 0, 0, 1, 0, "R8 rx read clears");
    for (int i = 0; i < N; i++) begin
      do_reset("R1 per-source reset");
      step(0, 13'(1 << i), 0, '0, 0, 0, 0, 0, 0, "R2 R4 single source");
      step(0, '0, 1, 32'(1 << i), 0, 0, 0, 0, 0, "R4 own mask bit hides it");
    end
    idle(0, "R2 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule